// File: doc/BRIEF.md
# Attribute-Coloured Bitmap Display Fetcher

This block produces a 256 by 192 pixel bitmap picture in which every 8 by 8 pixel cell takes its two colours from one attribute byte. It keeps its own horizontal and vertical position counters and computes the video RAM addresses for each display line. The bitmap row addresses follow an interleaved order: the line number is split into a third-of-screen field, a pixel-row-within-cell field and a cell-row field, and these are reordered. The block reads bitmap and attribute bytes through a synchronous read port with a latency of one cycle. It turns each bitmap byte into eight pixels, most significant bit first, and drives one 6-bit RGB value per clock, with two bits per channel.

Within every 16-pixel group the block makes four reads: a bitmap byte, its attribute, the next bitmap byte and the next attribute. Fetching runs one group ahead of display, so the first pixel of a line appears 16 clocks after its first read. An attribute byte gives the ink colour, the paper colour, a bright flag and a flash flag. A per-frame counter drives a flash phase. While that phase is active, a cell with its flash flag set shows with ink and paper exchanged. Outside the active area the block outputs a 3-bit border colour held in a register, always at normal brightness. Sync and blanking generation are not part of the block.

Top module: `attr_display_engine`

## Requirements
- R1: For display line L, the bitmap address at byte column c is L[7:6]·2048 + L[2:0]·256 + L[5:3]·32 + c. It is driven on `vram_addr` at horizontal position h = 16g + 0 with c = 2g, and at h = 16g + 4 with c = 2g + 1.
- R2: For display line L, the attribute address at byte column c is 6144 + (L div 8)·32 + c. It is driven at h = 16g + 2 with c = 2g, and at h = 16g + 6 with c = 2g + 1.
- R3: `vram_re` is 1 exactly when L < ACTIVE_LINES, h < 256 and (h mod 16) is one of 0, 2, 4 or 6. It is 0 at every other position, including all border lines.
- R4: Pixel X (0 to 255) of line L appears on `rgb` at position h = X + 16. It takes bit (7 − X mod 8) of its bitmap byte, so the most significant bit comes first. A 1 bit selects the ink colour, which is attribute bits 2:0. A 0 bit selects the paper colour, which is attribute bits 5:3.
- R5: Attribute bit 6 set raises every lit channel of both cell colours from level 2 to level 3.
- R6: When attribute bit 7 is set and the flash phase is 1, the bitmap byte is inverted before it is shown.
- R7: The flash counter is FLASH_W bits wide, starts at 0 and advances by one at the end of each frame. The flash phase is its top bit. With FLASH_W = 2, frames 0 and 1 have phase 0 and frame 2 has phase 1.
- R8: `rgb[5:4]` is red, `rgb[3:2]` is green and `rgb[1:0]` is blue. In a 3-bit colour value, bit 0 enables blue, bit 1 enables red and bit 2 enables green. A disabled channel is 0, so no channel ever shows the value 1.
- R9: Outside the active area, `rgb` shows the border register at level 2. A write with `border_we` takes effect at the position after the write cycle.
- R10: `in_display` is 1 exactly when L < ACTIVE_LINES and 16 ≤ h < 272.
- R11: During reset the position counters are at line 0, position 0, the border register is 0, `rgb` is 0 and `in_display` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low synchronous reset |
| border_in | input | 3 | New border colour |
| border_we | input | 1 | Loads `border_in` into the border register |
| vram_re | output | 1 | Read request to video RAM |
| vram_addr | output | VRAM_AW | Read address to video RAM |
| vram_data | input | 8 | Read data, valid one cycle after the request |
| rgb | output | 6 | Pixel colour, two bits per channel |
| in_display | output | 1 | High while `rgb` shows bitmap pixels |

## Verification
The assertions assume that the video RAM returns the addressed byte in the cycle after a read request, and that `border_in` and `border_we` change only between clock edges. The bench memory model returns a computed byte for each address after exactly one cycle, and all inputs are driven on the falling edge. The bench uses short line and frame lengths and a 2-bit flash counter, so that flash phase changes come within reach while the address arithmetic still covers every field of the line number.

// File: rtl/attr_disp_pkg.sv
package attr_disp_pkg;

  localparam int ACT_PIX   = 256;
  localparam int LOOKAHEAD = 16;
  localparam int ATTR_BASE = 6144;

  // interleaved bitmap row: third, pixel row in cell, cell row
  function automatic logic [12:0] row_base(input logic [7:0] line);
    return {line[7:6], line[2:0], line[5:3], 5'b00000};
  endfunction

  // one attribute row per eight lines, 32 bytes each
  function automatic logic [12:0] attr_row_base(input logic [7:0] line);
    return 13'(ATTR_BASE) + {3'b000, line[7:3], 5'b00000};
  endfunction

  // colour bits: 0 blue, 1 red, 2 green; out = {red, green, blue}
  function automatic logic [5:0] colour_rgb(input logic [2:0] col, input logic bright);
    logic [1:0] lvl;
    lvl = bright ? 2'd3 : 2'd2;
    return {col[1] ? lvl : 2'd0, col[2] ? lvl : 2'd0, col[0] ? lvl : 2'd0};
  endfunction

endpackage

// File: rtl/adf_timing.sv
module adf_timing #(
  parameter int H_TOTAL = 456,
  parameter int V_TOTAL = 311,
  parameter int FLASH_W = 5,
  localparam int HW = $clog2(H_TOTAL),
  localparam int VW = $clog2(V_TOTAL)
) (
  input  logic          clk,
  input  logic          rst_n,
  output logic [HW-1:0] h_cnt,
  output logic [VW-1:0] v_cnt,
  output logic          flash_phase
);

  logic [FLASH_W-1:0] frame_cnt;
  logic line_end;
  logic frame_end;

  assign line_end    = (h_cnt == HW'(H_TOTAL - 1));
  assign frame_end   = line_end && (v_cnt == VW'(V_TOTAL - 1));
  assign flash_phase = frame_cnt[FLASH_W-1];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      h_cnt     <= '0;
      v_cnt     <= '0;
      frame_cnt <= '0;
    end else begin
      h_cnt <= line_end ? '0 : h_cnt + 1'b1;
      if (line_end) v_cnt <= frame_end ? '0 : v_cnt + 1'b1;
      if (frame_end) frame_cnt <= frame_cnt + 1'b1;
    end
  end

endmodule

// File: rtl/adf_fetch.sv
module adf_fetch
  import attr_disp_pkg::*;
#(
  parameter int HW           = 9,
  parameter int VW           = 9,
  parameter int ACTIVE_LINES = 192,
  parameter int VRAM_AW      = 14
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [HW-1:0]      h_cnt,
  input  logic [VW-1:0]      v_cnt,
  input  logic [7:0]         vram_data,
  output logic               vram_re,
  output logic [VRAM_AW-1:0] vram_addr,
  output logic [3:0]         slot,
  output logic               disp_area,
  output logic               ld_strobe,
  output logic [7:0]         ld_pix,
  output logic [7:0]         ld_attr
);

  logic        row_on, fetch_on, capture;
  logic [12:0] base_sel, addr_sum;
  logic [7:0]  cap_p0, cap_a0, cap_p1, cap_a1;
  logic [7:0]  hold_p1, hold_a1;

  assign slot      = h_cnt[3:0];
  assign row_on    = v_cnt < VW'(ACTIVE_LINES);
  assign fetch_on  = row_on && (h_cnt < HW'(ACT_PIX));
  assign disp_area = row_on && (h_cnt >= HW'(LOOKAHEAD)) && (h_cnt < HW'(ACT_PIX + LOOKAHEAD));

  // reads on even slots of the first half of each group
  assign vram_re  = fetch_on && !slot[0] && !slot[3];
  assign base_sel = slot[1] ? attr_row_base(v_cnt[7:0]) : row_base(v_cnt[7:0]);
  assign addr_sum = base_sel + {8'b0, h_cnt[7:4], slot[2]};
  assign vram_addr = VRAM_AW'(addr_sum);

  // data of slot s arrives in slot s+1
  assign capture = fetch_on && slot[0] && !slot[3];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cap_p0  <= '0;
      cap_a0  <= '0;
      cap_p1  <= '0;
      cap_a1  <= '0;
      hold_p1 <= '0;
      hold_a1 <= '0;
    end else begin
      if (capture) begin
        case (slot[2:1])
          2'b00:   cap_p0 <= vram_data;
          2'b01:   cap_a0 <= vram_data;
          2'b10:   cap_p1 <= vram_data;
          default: cap_a1 <= vram_data;
        endcase
      end
      if (fetch_on && slot == 4'd15) begin
        hold_p1 <= cap_p1;
        hold_a1 <= cap_a1;
      end
    end
  end

  // first byte pair on slot 15 of the fetch group, second on slot 7 of the next
  assign ld_strobe = (fetch_on && slot == 4'd15) || (disp_area && slot == 4'd7);
  assign ld_pix    = slot[3] ? cap_p0 : hold_p1;
  assign ld_attr   = slot[3] ? cap_a0 : hold_a1;

endmodule

// File: rtl/adf_serializer.sv
module adf_serializer
  import attr_disp_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ld_strobe,
  input  logic [7:0] ld_pix,
  input  logic [7:0] ld_attr,
  input  logic       flash_phase,
  input  logic       disp_area,
  input  logic [2:0] border_in,
  input  logic       border_we,
  output logic [5:0] rgb
);

  logic [7:0] shreg;
  logic [7:0] cur_attr;
  logic [2:0] border_q;
  logic [2:0] pix_col;
  logic       invert;

  assign invert = ld_attr[7] & flash_phase;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      shreg    <= '0;
      cur_attr <= '0;
      border_q <= '0;
    end else begin
      if (border_we) border_q <= border_in;
      if (ld_strobe) begin
        shreg    <= ld_pix ^ {8{invert}};
        cur_attr <= ld_attr;
      end else begin
        shreg <= {shreg[6:0], 1'b0};
      end
    end
  end

  assign pix_col = shreg[7] ? cur_attr[2:0] : cur_attr[5:3];
  assign rgb     = disp_area ? colour_rgb(pix_col, cur_attr[6]) : colour_rgb(border_q, 1'b0);

endmodule

// File: rtl/attr_display_engine.sv
module attr_display_engine
  import attr_disp_pkg::*;
#(
  parameter int H_TOTAL      = 456,
  parameter int V_TOTAL      = 311,
  parameter int ACTIVE_LINES = 192,
  parameter int FLASH_W      = 5,
  parameter int VRAM_AW      = 14
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [2:0]         border_in,
  input  logic               border_we,
  output logic               vram_re,
  output logic [VRAM_AW-1:0] vram_addr,
  input  logic [7:0]         vram_data,
  output logic [5:0]         rgb,
  output logic               in_display
);

  localparam int HW = $clog2(H_TOTAL);
  localparam int VW = $clog2(V_TOTAL);

  logic [HW-1:0] h_cnt;
  logic [VW-1:0] v_cnt;
  logic          flash_phase;
  logic [3:0]    fetch_slot;
  logic          ld_strobe;
  logic [7:0]    ld_pix, ld_attr;

  adf_timing #(.H_TOTAL(H_TOTAL), .V_TOTAL(V_TOTAL), .FLASH_W(FLASH_W)) u_timing (
    .clk(clk), .rst_n(rst_n), .h_cnt(h_cnt), .v_cnt(v_cnt), .flash_phase(flash_phase)
  );

  adf_fetch #(.HW(HW), .VW(VW), .ACTIVE_LINES(ACTIVE_LINES), .VRAM_AW(VRAM_AW)) u_fetch (
    .clk(clk), .rst_n(rst_n), .h_cnt(h_cnt), .v_cnt(v_cnt), .vram_data(vram_data),
    .vram_re(vram_re), .vram_addr(vram_addr), .slot(fetch_slot), .disp_area(in_display),
    .ld_strobe(ld_strobe), .ld_pix(ld_pix), .ld_attr(ld_attr)
  );

  adf_serializer u_ser (
    .clk(clk), .rst_n(rst_n), .ld_strobe(ld_strobe), .ld_pix(ld_pix), .ld_attr(ld_attr),
    .flash_phase(flash_phase), .disp_area(in_display), .border_in(border_in),
    .border_we(border_we), .rgb(rgb)
  );

endmodule

// File: rtl/attr_display_engine_chk.sv
module attr_display_engine_chk #(
  parameter int HW      = 9,
  parameter int VRAM_AW = 14
) (
  input logic               clk,
  input logic               rst_n,
  input logic               vram_re,
  input logic [VRAM_AW-1:0] vram_addr,
  input logic [3:0]         slot,
  input logic [HW-1:0]      hpos,
  input logic               in_display,
  input logic [5:0]         rgb
);

  // R3
  re_even_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    vram_re |-> (!slot[0] && !slot[3]));

  // R1
  pix_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (vram_re && slot == 4'd4) |-> vram_addr == $past(vram_addr, 4) + 1'b1);

  // R2
  attr_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (vram_re && slot == 4'd6) |-> vram_addr == $past(vram_addr, 4) + 1'b1);

  // R10
  area_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(in_display) |-> hpos == HW'(16));

  // R8
  no_level_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rgb[5:4] != 2'd1) && (rgb[3:2] != 2'd1) && (rgb[1:0] != 2'd1));

  // R9
  border_dim_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_display |-> ((rgb[5:4] != 2'd3) && (rgb[3:2] != 2'd3) && (rgb[1:0] != 2'd3)));

endmodule

bind attr_display_engine attr_display_engine_chk #(.HW(HW), .VRAM_AW(VRAM_AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .vram_re(vram_re), .vram_addr(vram_addr), .slot(fetch_slot),
  .hpos(h_cnt), .in_display(in_display), .rgb(rgb)
);

// File: tb/attr_display_engine_bench.sv
`timescale 1ns/1ps
module attr_display_engine_bench;

  localparam int H  = 288;
  localparam int V  = 200;
  localparam int FW = 2;
  localparam int WATCHDOG = 190000;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] border_in = 3'd0;
  logic       border_we = 1'b0;
  logic       vram_re;
  logic [13:0] vram_addr;
  logic [7:0] vram_q = 8'd0;
  logic [5:0] rgb;
  logic       in_display;

  int cyc = 0;
  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  attr_display_engine #(.H_TOTAL(H), .V_TOTAL(V), .FLASH_W(FW)) u_attr_display_engine (
    .clk(clk), .rst_n(rst_n), .border_in(border_in), .border_we(border_we),
    .vram_re(vram_re), .vram_addr(vram_addr), .vram_data(vram_q),
    .rgb(rgb), .in_display(in_display)
  );

  function automatic int mem_f(int a);
    return (a * 73 + a / 5 + 11) % 256;
  endfunction

  always @(posedge clk) if (vram_re) vram_q <= 8'(mem_f(int'(vram_addr)));
  always @(posedge clk) if (rst_n) cyc <= cyc + 1;

  function automatic int pa(int l);
    return (l % 8) * 256 + ((l / 8) % 8) * 32 + (l / 64) * 2048;
  endfunction

  function automatic int aa(int l);
    return 6144 + (l / 8) * 32;
  endfunction

  function automatic int pal(int col, int lvl);
    return (((col / 2) % 2) ? lvl : 0) * 16 + (((col / 4) % 2) ? lvl : 0) * 4 + ((col % 2) ? lvl : 0);
  endfunction

  function automatic int pix_rgb(int l, int x, int ph);
    int pb, at, b, col;
    pb = mem_f(pa(l) + x / 8);
    at = mem_f(aa(l) + x / 8);
    b = (pb >> (7 - x % 8)) & 1;
    if (at >= 128 && ph != 0) b = 1 - b;
    col = b ? at % 8 : (at / 8) % 8;
    return pal(col, ((at / 64) % 2) ? 3 : 2);
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic wait_pos(input int target);
    while (cyc != target) @(negedge clk);
  endtask

  function automatic int pos(int f, int l, int h);
    return f * H * V + l * H + h;
  endfunction

  // full check of one position: reads, area flag and colour
  task automatic probe(input int f, input int l, input int h, input int bord);
    int s, exp_re, exp_area, exp_rgb;
    wait_pos(pos(f, l, h));
    s = h % 16;
    exp_re = (l < 192 && h < 256 && s < 8 && s % 2 == 0) ? 1 : 0;
    chk($sformatf("R3 re line %0d h %0d", l, h), int'(vram_re), exp_re);
    if (exp_re == 1) begin
      if ((s / 2) % 2 == 1)
        chk($sformatf("R2 addr line %0d h %0d", l, h), int'(vram_addr), aa(l) + 2 * (h / 16) + s / 4);
      else
        chk($sformatf("R1 addr line %0d h %0d", l, h), int'(vram_addr), pa(l) + 2 * (h / 16) + s / 4);
    end
    exp_area = (l < 192 && h >= 16 && h < 272) ? 1 : 0;
    chk($sformatf("R10 area line %0d h %0d", l, h), int'(in_display), exp_area);
    exp_rgb = exp_area ? pix_rgb(l, h - 16, (f / 2) % 2) : pal(bord, 2);
    chk($sformatf("R4 rgb line %0d h %0d", l, h), int'(rgb), exp_rgb);
  endtask

  task automatic sweep(input string tag, input int f, input int l);
    for (int h = 16; h < 272; h++) begin
      wait_pos(pos(f, l, h));
      chk($sformatf("%s line %0d pixel %0d", tag, l, h - 16), int'(rgb), pix_rgb(l, h - 16, (f / 2) % 2));
    end
  endtask

  localparam int NP = 16;
  localparam int P_LINE [NP] = '{0, 0, 0, 0, 0, 0, 0, 0, 9, 9, 9, 9, 65, 65, 130, 130};
  localparam int P_H    [NP] = '{0, 2, 4, 6, 7, 16, 23, 100, 254, 255, 262, 271, 30, 272, 8, 200};

  initial begin
    repeat (3) @(negedge clk);
    // R11 reset state
    chk("R11 rgb in reset", int'(rgb), 0);
    chk("R11 in_display in reset", int'(in_display), 0);
    rst_n = 1'b1;

    for (int i = 0; i < NP; i++) probe(0, P_LINE[i], P_H[i], 0);

    sweep("R5 bright/ink/paper", 0, 150);
    sweep("R8 palette", 0, 191);

    // R9 border write visible one position later
    wait_pos(pos(0, 191, 276));
    chk("R9 border before write", int'(rgb), 0);
    border_in = 3'd6;
    border_we = 1'b1;
    @(negedge clk);
    border_we = 1'b0;
    chk("R9 border after write", int'(rgb), 40);
    probe(0, 195, 100, 6);
    chk("R9 border dim on border line", int'(rgb), pal(6, 2));

    sweep("R7 phase 0 in frame 1", 1, 0);
    probe(2, 9, 5, 6);
    sweep("R6 flash inverted in frame 2", 2, 9);
    probe(2, 9, 280, 6);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(WATCHDOG * 5.0);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule